// File: doc/BRIEF.md
# Serial Audio Front End with Clock-Driven Mode Control

This block sits in front of a mono amplifier that receives a two-slot serial audio stream (bit clock, word select, data). It has no software register interface: its operating mode follows from which clocks are present. A free-running system clock oversamples the bit clock and the two word-select inputs. When the bit clock is missing, the block is powered down. When the bit clock runs but no word select toggles, it is muted. When both run, it produces one output sample per frame.

The word-select wiring chooses the channel. A toggling signal on only the left-select input takes the left slot. On only the right-select input it takes the right slot. On both inputs it takes the mean of the two slots.

Right after reset there is a startup window. During it, word select is held low and the data line carries configuration bytes, most significant bit first. The bytes set a clip-control flag and one of three gain steps. The window closes after a fixed number of bit-clock edges, or earlier when an end byte arrives.

Top module: `amp_fe_ctrl`

## Requirements
- R1: After reset, and after every bit-clock loss, `mode` stays 00 (power-down) until PRESENT_EDGES rising bit-clock edges have been seen, each arriving within LOSS_TIMEOUT system cycles of the one before.
- R2: When no rising bit-clock edge is seen for LOSS_TIMEOUT system cycles, `mode` returns to 00 (power-down).
- R3: With the bit clock present, `mode` is 01 (mute) while the startup window is open. It is also 01 while neither word-select input has toggled within the last WS_LOSS_BITS bit-clock edges.
- R4: With the bit clock present, the window closed and at least one word-select input toggling, `mode` is 10 (operating).
- R5: Frame format: a word-select low slot carries the left word and a high slot carries the right word. Each word is 16-bit two's complement, MSB first. The MSB is on the first rising bit-clock edge after the word-select change. With only the left-select input toggling, each complete frame gives one `sample_valid` pulse with `sample_out` equal to the left word.
- R6: With only the right-select input toggling, that input acts as the word clock and `sample_out` equals the right word.
- R7: With both inputs toggling, `sample_out` is (left + right) arithmetically shifted right by one, with the sum formed at 17 bits.
- R8: Outside mode 10, `sample_out` is zero and `sample_valid` stays low.
- R9: The startup window spans the first STARTUP_BITS rising bit-clock edges after reset. Bytes are framed from the first edge, 8 edges each, MSB first. The window closes early on byte 0xAA. `cfg_done` goes high when it closes and stays high until reset.
- R10: `clip_en` is 0 after reset. Byte 0xD2 inside the window sets it, and it then stays set until reset.
- R11: `gain_sel` is 01 (0 dB) after reset. Within the window, byte 0xC0 selects 00 (−3 dB), 0xC1 selects 01 (0 dB) and 0xC2 selects 10 (+3 dB). The value 11 never appears.
- R12: Bytes with no assigned meaning inside the window leave `clip_en` and `gain_sel` unchanged. Every byte arriving after the window closes is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Serial bit clock (asynchronous) |
| wsl_in | input | 1 | Left-select word clock input |
| wsr_in | input | 1 | Right-select word clock input |
| sdata_in | input | 1 | Serial data: configuration bytes, then audio |
| mode | output | 2 | 00 power-down, 01 mute, 10 operating |
| sample_out | output | DW | Output audio sample |
| sample_valid | output | 1 | One-cycle pulse per produced sample |
| clip_en | output | 1 | Clip control enabled |
| gain_sel | output | 2 | Gain step: 00 −3 dB, 01 0 dB, 10 +3 dB |
| cfg_done | output | 1 | Startup window has closed |

## Verification
The hardest state to reach is a change of channel selection. When the left-select input stops and the right-select input starts, the stale left-activity flag lingers for WS_LOSS_BITS edges. During that time the block still sees both inputs and mixes. The stimulus therefore runs four warm-up frames after every wiring change and only then compares a sweep of extreme sample pairs. Closing the startup window by timeout is a separate case: it needs a fresh reset, and is driven with a full window of filler bytes that carry no end byte. Then a clip byte sent after the window is shown to have no effect.

// File: rtl/amp_fe_pkg.sv
`timescale 1ns/1ps
package amp_fe_pkg;

    typedef enum logic [1:0] {
        MODE_PDN  = 2'b00,
        MODE_MUTE = 2'b01,
        MODE_OPER = 2'b10
    } amp_mode_e;

    typedef enum logic [1:0] {
        CH_NONE  = 2'b00,
        CH_LEFT  = 2'b01,
        CH_RIGHT = 2'b10,
        CH_MONO  = 2'b11
    } chan_e;

    localparam logic [7:0] CMD_END     = 8'hAA;
    localparam logic [7:0] CMD_CLIP_ON = 8'hD2;
    localparam logic [7:0] CMD_GAIN_M3 = 8'hC0;
    localparam logic [7:0] CMD_GAIN_0  = 8'hC1;
    localparam logic [7:0] CMD_GAIN_P3 = 8'hC2;

    localparam logic [1:0] GAIN_M3 = 2'b00;
    localparam logic [1:0] GAIN_0  = 2'b01;
    localparam logic [1:0] GAIN_P3 = 2'b10;

    typedef struct packed {
        logic       clip_on;
        logic [1:0] gain;
        logic       done;
    } cfg_t;

    function automatic chan_e chan_from_ws(input logic left_on, input logic right_on);
        case ({right_on, left_on})
            2'b01:   return CH_LEFT;
            2'b10:   return CH_RIGHT;
            2'b11:   return CH_MONO;
            default: return CH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/amp_fe_bck_mon.sv
`timescale 1ns/1ps
module amp_fe_bck_mon #(
    parameter int PRESENT_EDGES = 8,
    parameter int LOSS_TIMEOUT  = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic bck_s,
    output logic bck_rise,
    output logic bck_active
);
    localparam int EW = $clog2(PRESENT_EDGES + 1);
    localparam int IW = $clog2(LOSS_TIMEOUT + 1);

    logic          bck_d;
    logic [EW-1:0] edge_cnt;
    logic [IW-1:0] idle_cnt;

    assign bck_rise = bck_s & ~bck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            bck_d      <= 1'b0;
            edge_cnt   <= '0;
            idle_cnt   <= '0;
            bck_active <= 1'b0;
        end else begin
            bck_d <= bck_s;
            if (bck_rise) begin
                idle_cnt <= '0;
                if (!bck_active) begin
                    if (edge_cnt == EW'(PRESENT_EDGES - 1)) begin
                        bck_active <= 1'b1;
                        edge_cnt   <= '0;
                    end else begin
                        edge_cnt <= edge_cnt + 1'b1;
                    end
                end
            end else if (idle_cnt == IW'(LOSS_TIMEOUT - 1)) begin
                bck_active <= 1'b0;
                edge_cnt   <= '0;
            end else begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/amp_fe_cfg_rx.sv
`timescale 1ns/1ps
module amp_fe_cfg_rx
    import amp_fe_pkg::*;
#(
    parameter int STARTUP_BITS = 12288
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic sd,
    output cfg_t cfg
);
    localparam int WW = $clog2(STARTUP_BITS + 1);

    logic [WW-1:0] win_cnt;
    logic [6:0]    byte_sh;
    logic [2:0]    bit_idx;
    logic [7:0]    byte_v;
    logic          byte_end;

    assign byte_v   = {byte_sh, sd};
    assign byte_end = (bit_idx == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt     <= '0;
            byte_sh     <= '0;
            bit_idx     <= '0;
            cfg.clip_on <= 1'b0;
            cfg.gain    <= GAIN_0;
            cfg.done    <= 1'b0;
        end else if (bit_stb && !cfg.done) begin
            byte_sh <= {byte_sh[5:0], sd};
            bit_idx <= bit_idx + 1'b1;
            win_cnt <= win_cnt + 1'b1;
            if (byte_end) begin
                case (byte_v)
                    CMD_CLIP_ON: cfg.clip_on <= 1'b1;
                    CMD_GAIN_M3: cfg.gain    <= GAIN_M3;
                    CMD_GAIN_0:  cfg.gain    <= GAIN_0;
                    CMD_GAIN_P3: cfg.gain    <= GAIN_P3;
                    default:     ;
                endcase
            end
            if ((win_cnt == WW'(STARTUP_BITS - 1)) || (byte_end && byte_v == CMD_END))
                cfg.done <= 1'b1;
        end
    end
endmodule

// File: rtl/amp_fe_ws_watch.sv
`timescale 1ns/1ps
module amp_fe_ws_watch #(
    parameter int LOSS_BITS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic bit_stb,
    input  logic ws,
    output logic ws_on
);
    localparam int CW = $clog2(LOSS_BITS + 1);

    logic          ws_prev;
    logic [CW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_prev   <= 1'b0;
            quiet_cnt <= '0;
            ws_on     <= 1'b0;
        end else if (!enable) begin
            ws_prev   <= ws;
            quiet_cnt <= '0;
            ws_on     <= 1'b0;
        end else if (bit_stb) begin
            ws_prev <= ws;
            if (ws != ws_prev) begin
                ws_on     <= 1'b1;
                quiet_cnt <= '0;
            end else if (ws_on) begin
                if (quiet_cnt == CW'(LOSS_BITS - 1)) begin
                    ws_on     <= 1'b0;
                    quiet_cnt <= '0;
                end else begin
                    quiet_cnt <= quiet_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/amp_fe_frame_rx.sv
`timescale 1ns/1ps
module amp_fe_frame_rx #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          bit_stb,
    input  logic          ws,
    input  logic          sd,
    output logic          frame_done,
    output logic [DW-1:0] left_word,
    output logic [DW-1:0] right_word
);
    localparam int CW = $clog2(DW) + 1;
    localparam logic [CW-1:0] CNT_MAX  = '1;
    localparam logic [CW-1:0] CNT_FULL = CW'(DW - 1);

    logic          ws_prev;
    logic [CW-1:0] bit_cnt;
    logic [DW-2:0] shreg;
    logic          left_ok;
    logic [DW-1:0] word_v;

    assign word_v = {shreg, sd};

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_prev    <= 1'b0;
            bit_cnt    <= CNT_MAX;
            shreg      <= '0;
            left_ok    <= 1'b0;
            frame_done <= 1'b0;
            left_word  <= '0;
            right_word <= '0;
        end else if (!enable) begin
            ws_prev    <= ws;
            bit_cnt    <= CNT_MAX;
            left_ok    <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (bit_stb) begin
                ws_prev <= ws;
                shreg   <= {shreg[DW-3:0], sd};
                if (ws != ws_prev) begin
                    bit_cnt <= '0;
                    if (bit_cnt != CNT_FULL) begin
                        left_ok <= 1'b0;
                    end else if (!ws_prev) begin
                        left_word <= word_v;
                        left_ok   <= 1'b1;
                    end else begin
                        left_ok <= 1'b0;
                        if (left_ok) begin
                            right_word <= word_v;
                            frame_done <= 1'b1;
                        end
                    end
                end else if (bit_cnt != CNT_MAX) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/amp_fe_ctrl.sv
`timescale 1ns/1ps
module amp_fe_ctrl
    import amp_fe_pkg::*;
#(
    parameter int DW            = 16,
    parameter int STARTUP_BITS  = 12288,
    parameter int LOSS_TIMEOUT  = 256,
    parameter int PRESENT_EDGES = 8,
    parameter int WS_LOSS_BITS  = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bck_in,
    input  logic          wsl_in,
    input  logic          wsr_in,
    input  logic          sdata_in,
    output logic [1:0]    mode,
    output logic [DW-1:0] sample_out,
    output logic          sample_valid,
    output logic          clip_en,
    output logic [1:0]    gain_sel,
    output logic          cfg_done
);
    localparam int NWS = 2;

    logic [3:0] sync1, sync2;
    logic       bck_s, wsl_s, wsr_s, sd_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
        end else begin
            sync1 <= {bck_in, wsl_in, wsr_in, sdata_in};
            sync2 <= sync1;
        end
    end
    assign {bck_s, wsl_s, wsr_s, sd_s} = sync2;

    logic bck_rise, bck_active;

    amp_fe_bck_mon #(
        .PRESENT_EDGES (PRESENT_EDGES),
        .LOSS_TIMEOUT  (LOSS_TIMEOUT)
    ) i_bck_mon (
        .clk        (clk),
        .rst        (rst),
        .bck_s      (bck_s),
        .bck_rise   (bck_rise),
        .bck_active (bck_active)
    );

    cfg_t cfg;

    amp_fe_cfg_rx #(
        .STARTUP_BITS (STARTUP_BITS)
    ) i_cfg_rx (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bck_rise),
        .sd      (sd_s),
        .cfg     (cfg)
    );

    logic           ws_en;
    logic [NWS-1:0] ws_lines, ws_on;

    assign ws_en    = bck_active & cfg.done;
    assign ws_lines = {wsr_s, wsl_s};

    for (genvar g = 0; g < NWS; g++) begin : g_ws
        amp_fe_ws_watch #(
            .LOSS_BITS (WS_LOSS_BITS)
        ) i_ws_watch (
            .clk     (clk),
            .rst     (rst),
            .enable  (ws_en),
            .bit_stb (bck_rise),
            .ws      (ws_lines[g]),
            .ws_on   (ws_on[g])
        );
    end

    chan_e chan;
    assign chan = chan_from_ws(ws_on[0], ws_on[1]);

    logic          frame_done;
    logic [DW-1:0] left_word, right_word;
    logic          frame_en, ws_sel;

    assign frame_en = ws_en && (chan != CH_NONE);
    assign ws_sel   = (chan == CH_RIGHT) ? wsr_s : wsl_s;

    amp_fe_frame_rx #(
        .DW (DW)
    ) i_frame_rx (
        .clk        (clk),
        .rst        (rst),
        .enable     (frame_en),
        .bit_stb    (bck_rise),
        .ws         (ws_sel),
        .sd         (sd_s),
        .frame_done (frame_done),
        .left_word  (left_word),
        .right_word (right_word)
    );

    amp_mode_e mode_d, mode_q;

    always_comb begin
        if (!bck_active)
            mode_d = MODE_PDN;
        else if (cfg.done && chan != CH_NONE)
            mode_d = MODE_OPER;
        else
            mode_d = MODE_MUTE;
    end

    logic [DW:0]   mix_sum;
    logic [DW-1:0] pick;

    assign mix_sum = {left_word[DW-1], left_word} + {right_word[DW-1], right_word};

    always_comb begin
        case (chan)
            CH_LEFT:  pick = left_word;
            CH_RIGHT: pick = right_word;
            CH_MONO:  pick = mix_sum[DW:1];
            default:  pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= MODE_PDN;
            sample_out   <= '0;
            sample_valid <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (mode_q != MODE_OPER) begin
                sample_out   <= '0;
                sample_valid <= 1'b0;
            end else if (frame_done) begin
                sample_out   <= pick;
                sample_valid <= 1'b1;
            end else begin
                sample_valid <= 1'b0;
            end
        end
    end

    assign mode     = mode_q;
    assign clip_en  = cfg.clip_on;
    assign gain_sel = cfg.gain;
    assign cfg_done = cfg.done;
endmodule

// File: rtl/amp_fe_ctrl_chk.sv
`timescale 1ns/1ps
module amp_fe_ctrl_chk
    import amp_fe_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    mode,
    input logic [DW-1:0] sample_out,
    input logic          sample_valid,
    input logic          clip_en,
    input logic [1:0]    gain_sel,
    input logic          cfg_done
);
    // R8
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_OPER) |=> (sample_out == '0));

    // R8
    valid_mode_chk: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> ($past(mode) == MODE_OPER));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> cfg_done);

    // R10
    clip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        clip_en |=> clip_en);

    // R12
    gain_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |=> $stable(gain_sel));

    // R11
    gain_code_chk: assert property (@(posedge clk) disable iff (rst)
        gain_sel != 2'b11);

    // R3
    mode_code_chk: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);
endmodule

bind amp_fe_ctrl amp_fe_ctrl_chk #(.DW(DW)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .mode         (mode),
    .sample_out   (sample_out),
    .sample_valid (sample_valid),
    .clip_en      (clip_en),
    .gain_sel     (gain_sel),
    .cfg_done     (cfg_done)
);

// File: tb/test_amp_fe_ctrl.sv
`timescale 1ns/1ps
module test_amp_fe_ctrl;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bck = 1'b0, wsl = 1'b0, wsr = 1'b0, sd = 1'b0;
    logic [1:0]    mode;
    logic [DW-1:0] sample_out;
    logic          sample_valid, clip_en, cfg_done;
    logic [1:0]    gain_sel;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] got_sample = '0;
    int          got_cnt = 0;
    logic [15:0] prev_r = '0;

    always #2.5 clk = ~clk;

    amp_fe_ctrl #(
        .DW(DW), .STARTUP_BITS(128), .LOSS_TIMEOUT(40),
        .PRESENT_EDGES(4), .WS_LOSS_BITS(64)
    ) i_amp_fe_ctrl (
        .clk(clk), .rst(rst), .bck_in(bck), .wsl_in(wsl), .wsr_in(wsr),
        .sdata_in(sd), .mode(mode), .sample_out(sample_out),
        .sample_valid(sample_valid), .clip_en(clip_en),
        .gain_sel(gain_sel), .cfg_done(cfg_done)
    );

    always @(negedge clk) begin
        if (sample_valid) begin
            got_sample <= sample_out;
            got_cnt    <= got_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; bck = 1'b0; wsl = 1'b0; wsr = 1'b0; sd = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic l, input logic r, input logic d);
        @(negedge clk);
        wsl = l; wsr = r; sd = d; bck = 1'b0;
        repeat (4) @(negedge clk);
        bck = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(1'b0, 1'b0, b[i]);
        repeat (6) @(negedge clk);
    endtask

    task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input bit use_l, input bit use_r);
        for (int j = 0; j < 32; j++) begin
            logic w, d;
            w = (j >= 16);
            if (j == 0)       d = prev_r[0];
            else if (j <= 15) d = l[16-j];
            else if (j == 16) d = l[0];
            else              d = r[32-j];
            send_bit(use_l ? w : 1'b0, use_r ? w : 1'b0, d);
        end
        prev_r = r;
    endtask

    function automatic logic [15:0] expect_out(input int sel, input logic [15:0] l, input logic [15:0] r);
        int s;
        s = int'($signed(l)) + int'($signed(r));
        s = s >>> 1;
        if (sel == 1) return l;
        if (sel == 2) return r;
        return s[15:0];
    endfunction

    logic [15:0] vals [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h5A3C};

    task automatic run_group(input int sel, input string req);
        bit ul, ur;
        logic [15:0] pending;
        ul = (sel != 2);
        ur = (sel != 1);
        for (int k = 0; k < 4; k++) send_frame(16'h1234, 16'hEDCB, ul, ur);
        pending = expect_out(sel, 16'h1234, 16'hEDCB);
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                send_frame(vals[a], vals[b], ul, ur);
                check(got_sample == pending, req, got_sample, pending);
                pending = expect_out(sel, vals[a], vals[b]);
            end
        end
        send_frame(16'h0000, 16'h0000, ul, ur);
        check(got_sample == pending, req, got_sample, pending);
        check(mode == 2'b10, "R4", mode, 2'b10);
    endtask

    initial begin
        int cnt_hold;
        do_reset();
        // R1 R10 R11 reset state
        check(mode == 2'b00, "R1", mode, 0);
        check(sample_out == '0, "R8", sample_out, 0);
        check(clip_en == 1'b0, "R10", clip_en, 0);
        check(gain_sel == 2'b01, "R11", gain_sel, 1);
        check(cfg_done == 1'b0, "R9", cfg_done, 0);

        // Window closed by timeout
        send_byte(8'hC0);
        check(gain_sel == 2'b00, "R11", gain_sel, 0);
        check(mode == 2'b01, "R3", mode, 1);
        for (int i = 0; i < 14; i++) send_byte(8'h00);
        check(cfg_done == 1'b0, "R9", cfg_done, 0);
        send_byte(8'h00);
        check(cfg_done == 1'b1, "R9", cfg_done, 1);
        send_byte(8'hD2);
        check(clip_en == 1'b0, "R12", clip_en, 0);
        check(gain_sel == 2'b00, "R12", gain_sel, 0);
        check(mode == 2'b01, "R3", mode, 1);

        // Window closed by end byte
        do_reset();
        send_byte(8'h37);
        check(gain_sel == 2'b01 && clip_en == 1'b0, "R12", {gain_sel, clip_en}, 3'b010);
        check(mode == 2'b01, "R3", mode, 1);
        send_byte(8'hC2);
        check(gain_sel == 2'b10, "R11", gain_sel, 2);
        send_byte(8'hD2);
        check(clip_en == 1'b1, "R10", clip_en, 1);
        check(cfg_done == 1'b0, "R9", cfg_done, 0);
        send_byte(8'hAA);
        check(cfg_done == 1'b1, "R9", cfg_done, 1);
        check(mode == 2'b01, "R3", mode, 1);

        // Channel sweeps
        run_group(1, "R5");
        run_group(2, "R6");
        run_group(3, "R7");

        // Word select off: mute
        for (int i = 0; i < 70; i++) send_bit(1'b0, 1'b0, 1'b1);
        check(mode == 2'b01, "R3", mode, 1);
        cnt_hold = got_cnt;
        for (int i = 0; i < 30; i++) send_bit(1'b0, 1'b0, 1'b1);
        check(sample_out == '0, "R8", sample_out, 0);
        check(got_cnt == cnt_hold, "R8", got_cnt, cnt_hold);
        check(clip_en == 1'b1, "R10", clip_en, 1);

        // Bit clock stops: power-down
        bck = 1'b0;
        repeat (60) @(negedge clk);
        check(mode == 2'b00, "R2", mode, 0);

        // Bit clock returns
        send_bit(1'b0, 1'b0, 1'b0);
        send_bit(1'b0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        check(mode == 2'b00, "R1", mode, 0);
        for (int k = 0; k < 3; k++) send_frame(16'h0101, 16'h0202, 1'b1, 1'b0);
        check(mode == 2'b10, "R4", mode, 2);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule